// File: doc/BRIEF.md
# Revertive Reference Clock Selector

This block watches two reference clocks, a main one and a backup one, and decides which of them the downstream clocking logic should use. It runs on its own free-running monitor clock. Both references are brought into that domain and turned into single-cycle rising-edge pulses. The main reference is declared missing by counting backup edges that arrive with no main edge between them.

When the main reference is declared missing, the selection moves to the backup and a loss flag goes high. The block keeps watching the main input. Once the main input has delivered a run of consecutive edges with no long gap, the block returns to the main reference by itself and drops the flag. The block drives a registered select level and does not mux any clock. A manual select pin is present only so that the bench can show that it has no effect.

The controller has three states:
- ON_MAIN: running on the main reference.
- ON_BACKUP: running on the backup, with the main reference silent.
- QUALIFYING: running on the backup while counting main edges toward a return.

It has five transitions:
- ON_MAIN to ON_BACKUP on a gap expiry.
- ON_BACKUP to QUALIFYING on a main edge.
- QUALIFYING to QUALIFYING on a main edge that is not the last one needed, which increments the count.
- QUALIFYING to ON_MAIN on the main edge that completes the run.
- QUALIFYING to ON_BACKUP on a gap expiry, which clears the count.

Top module: `refsel_monitor`

## Requirements
- R1: While reset is low, and after it is released with both references running, `use_secondary` and `pri_lost` are 0.
- R2: When the main reference stops with the backup running, `use_secondary` and `pri_lost` go to 1. The gap counter reaches 3 backup rising edges with no main rising edge between them, which means at least two full backup periods have passed.
- R3: A main reference that keeps toggling never causes a switch, whether it runs faster than the backup or slower than it (a period below twice the backup period).
- R4: After a loss, the selection returns to the main reference and `pri_lost` clears on the 16th consecutive main rising edge. In this count no gap may reach the loss threshold of R2.
- R5: With fewer than 16 qualifying main edges since the loss, the outputs remain at 1.
- R6: A gap that reaches the loss threshold during qualification restarts the edge count from zero.
- R7: If both references stop, the current selection and loss flag hold.
- R8: `manual_pick` has no effect on either output.
- R9: `pri_lost` always equals `use_secondary`, and both come from registers on `clk_mon`.

Each edge counted above is a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_clk | input | 1 | Main reference clock (asynchronous) |
| sec_clk | input | 1 | Backup reference clock (asynchronous) |
| manual_pick | input | 1 | Manual select pin, ignored |
| use_secondary | output | 1 | 1 selects the backup reference |
| pri_lost | output | 1 | 1 while the main reference is considered lost |

## Verification
The bench runs the main reference both faster than the backup and nearly twice as slow. A detector with too low a threshold would switch on frequency alone and fail those checks. It then interrupts a partial qualification run with a second outage. A design that did not clear its count would return to the main reference too early. Stopping both references checks that a design which misreads silence as recovery, or drops the flag, is caught. The manual pin is toggled throughout, so any path from it to the outputs shows up as a wrong selection.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        ST_ON_MAIN    = 2'd0,
        ST_ON_BACKUP  = 2'd1,
        ST_QUALIFYING = 2'd2
    } refsel_state_t;

endpackage

// File: rtl/refsel_edge_sync.sv
module refsel_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int TOP = (STAGES < 2) ? 1 : STAGES - 1;

    logic [TOP:0] sync_q;
    logic         last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '0;
            last_q     <= 1'b0;
            rise_pulse <= 1'b0;
        end else begin
            sync_q     <= {sync_q[TOP-1:0], async_in};
            last_q     <= sync_q[TOP];
            rise_pulse <= sync_q[TOP] & ~last_q;
        end
    end
endmodule

// File: rtl/refsel_gap_counter.sv
module refsel_gap_counter #(
    parameter int LOSS_EDGES = 3,
    parameter int GAP_W      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_rise,
    input  logic sec_rise,
    output logic gap_expired
);
    localparam logic [GAP_W-1:0] LIMIT = GAP_W'(LOSS_EDGES);

    logic [GAP_W-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (pri_rise) begin
            gap_cnt <= '0;
        end else if (sec_rise && gap_cnt != LIMIT) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign gap_expired = (gap_cnt == LIMIT);
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
#(
    parameter int QUAL_EDGES = 16,
    parameter int QUAL_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_rise,
    input  logic              gap_expired,
    output logic              use_secondary,
    output logic              pri_lost,
    output logic [QUAL_W-1:0] qual_cnt
);
    localparam logic [QUAL_W-1:0] QUAL_LAST = QUAL_W'(QUAL_EDGES - 1);

    refsel_state_t    state_q, state_nx;
    logic [QUAL_W-1:0] qual_nx;

    always_comb begin
        state_nx = state_q;
        qual_nx  = qual_cnt;
        unique case (state_q)
            ST_ON_MAIN: begin
                qual_nx = '0;
                if (gap_expired) state_nx = ST_ON_BACKUP;
            end
            ST_ON_BACKUP: begin
                if (pri_rise) begin
                    state_nx = ST_QUALIFYING;
                    qual_nx  = QUAL_W'(1);
                end
            end
            ST_QUALIFYING: begin
                if (pri_rise) begin
                    if (qual_cnt == QUAL_LAST) begin
                        state_nx = ST_ON_MAIN;
                        qual_nx  = '0;
                    end else begin
                        qual_nx = qual_cnt + 1'b1;
                    end
                end else if (gap_expired) begin
                    state_nx = ST_ON_BACKUP;
                    qual_nx  = '0;
                end
            end
            default: begin
                state_nx = ST_ON_MAIN;
                qual_nx  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_ON_MAIN;
            qual_cnt <= '0;
        end else begin
            state_q  <= state_nx;
            qual_cnt <= qual_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_secondary <= 1'b0;
            pri_lost      <= 1'b0;
        end else begin
            use_secondary <= (state_nx != ST_ON_MAIN);
            pri_lost      <= (state_nx != ST_ON_MAIN);
        end
    end
endmodule

// File: rtl/refsel_monitor.sv
module refsel_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_EDGES  = 3,
    parameter int QUAL_EDGES  = 16
) (
    input  logic clk_mon,
    input  logic rst_n,
    input  logic pri_clk,
    input  logic sec_clk,
    input  logic manual_pick,
    output logic use_secondary,
    output logic pri_lost
);
    localparam int GAP_W  = $clog2(LOSS_EDGES + 1);
    localparam int QUAL_W = $clog2(QUAL_EDGES + 1);
    localparam int NREF   = 2;

    logic [NREF-1:0]   ref_raw;
    logic [NREF-1:0]   ref_rise;
    logic              pri_rise;
    logic              sec_rise;
    logic              gap_expired;
    logic [QUAL_W-1:0] qual_cnt;
    logic              manual_unused;

    assign ref_raw       = {sec_clk, pri_clk};
    assign manual_unused = manual_pick;

    for (genvar gi = 0; gi < NREF; gi++) begin : g_sync
        refsel_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk_mon),
            .rst_n     (rst_n),
            .async_in  (ref_raw[gi]),
            .rise_pulse(ref_rise[gi])
        );
    end

    assign pri_rise = ref_rise[0];
    assign sec_rise = ref_rise[1];

    refsel_gap_counter #(.LOSS_EDGES(LOSS_EDGES), .GAP_W(GAP_W)) u_gap (
        .clk        (clk_mon),
        .rst_n      (rst_n),
        .pri_rise   (pri_rise),
        .sec_rise   (sec_rise),
        .gap_expired(gap_expired)
    );

    refsel_fsm #(.QUAL_EDGES(QUAL_EDGES), .QUAL_W(QUAL_W)) u_fsm (
        .clk          (clk_mon),
        .rst_n        (rst_n),
        .pri_rise     (pri_rise),
        .gap_expired  (gap_expired),
        .use_secondary(use_secondary),
        .pri_lost     (pri_lost),
        .qual_cnt     (qual_cnt)
    );
endmodule

// File: rtl/refsel_monitor_chk.sv
module refsel_monitor_chk #(
    parameter int QUAL_EDGES = 16,
    parameter int QUAL_W     = 5
) (
    input logic              clk_mon,
    input logic              rst_n,
    input logic              use_secondary,
    input logic              pri_lost,
    input logic              pri_rise,
    input logic              gap_expired,
    input logic [QUAL_W-1:0] qual_cnt
);
    p_reset_primary_r1: assert property (@(posedge clk_mon)
        !rst_n |=> (!use_secondary && !pri_lost));

    p_switch_after_gap_r2: assert property (@(posedge clk_mon) disable iff (!rst_n)
        $rose(use_secondary) |-> $past(gap_expired));

    p_edge_clears_gap_r3: assert property (@(posedge clk_mon) disable iff (!rst_n)
        pri_rise |=> !gap_expired);

    p_revert_on_edge_r4: assert property (@(posedge clk_mon) disable iff (!rst_n)
        $fell(use_secondary) |-> $past(pri_rise));

    p_qual_bounded_r5: assert property (@(posedge clk_mon) disable iff (!rst_n)
        qual_cnt < QUAL_W'(QUAL_EDGES));

    p_flag_tracks_select_r9: assert property (@(posedge clk_mon) disable iff (!rst_n)
        pri_lost == use_secondary);
endmodule

bind refsel_monitor refsel_monitor_chk #(.QUAL_EDGES(QUAL_EDGES), .QUAL_W(QUAL_W)) u_chk (
    .clk_mon      (clk_mon),
    .rst_n        (rst_n),
    .use_secondary(use_secondary),
    .pri_lost     (pri_lost),
    .pri_rise     (pri_rise),
    .gap_expired  (gap_expired),
    .qual_cnt     (qual_cnt)
);

// File: tb/sim_refsel_monitor.sv
`timescale 1ns/1ps
module sim_refsel_monitor;
    logic clk_mon = 1'b0;
    logic rst_n = 1'b0;
    logic pri_clk = 1'b0;
    logic sec_clk = 1'b0;
    logic manual_pick = 1'b0;
    logic use_secondary;
    logic pri_lost;

    bit pri_en = 1'b1;
    bit sec_en = 1'b1;
    int pri_half = 40;
    int sec_half = 40;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    exp_sec;
        string tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    refsel_monitor u0 (
        .clk_mon      (clk_mon),
        .rst_n        (rst_n),
        .pri_clk      (pri_clk),
        .sec_clk      (sec_clk),
        .manual_pick  (manual_pick),
        .use_secondary(use_secondary),
        .pri_lost     (pri_lost)
    );

    always #4 clk_mon = ~clk_mon;

    always begin
        #(pri_half);
        if (pri_en) pri_clk = ~pri_clk;
    end

    always begin
        #(sec_half);
        if (sec_en) sec_clk = ~sec_clk;
    end

    task automatic push_expect(input bit e, input string tag);
        exp_item_t it;
        it.exp_sec = e;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk_mon);
        @(negedge clk_mon);
    endtask

    always @(negedge clk_mon) begin
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (use_secondary !== it.exp_sec || pri_lost !== it.exp_sec) begin
                errors++;
                $display("FAIL %s: use_secondary=%b pri_lost=%b expected %b", it.tag,
                         use_secondary, pri_lost, it.exp_sec);
            end
            checks++;
            if (pri_lost !== use_secondary) begin
                errors++;
                $display("FAIL R9: pri_lost=%b expected %b", pri_lost, use_secondary);
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual running expected done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk_mon);
        push_expect(1'b0, "R1 during reset");
        rst_n = 1'b1;
        #1000;
        push_expect(1'b0, "R1 healthy after reset");

        manual_pick = 1'b1;
        #300;
        manual_pick = 1'b0;
        #200;
        manual_pick = 1'b1;
        #200;
        push_expect(1'b0, "R8 manual pin on main");

        pri_half = 70;
        #2500;
        push_expect(1'b0, "R3 slower main");
        pri_half = 24;
        #1500;
        push_expect(1'b0, "R3 faster main");
        pri_half = 40;
        #500;

        pri_en = 1'b0;
        #600;
        push_expect(1'b1, "R2 main stopped");
        manual_pick = 1'b0;
        #300;
        push_expect(1'b1, "R8 manual pin on backup");

        pri_en = 1'b1;
        #800;
        push_expect(1'b1, "R5 partial qualification");
        pri_en = 1'b0;
        #600;
        push_expect(1'b1, "R6 outage during qualification");
        pri_en = 1'b1;
        #1000;
        push_expect(1'b1, "R6 count restarted");
        #1200;
        push_expect(1'b0, "R4 revert after qualification");

        pri_en = 1'b0;
        #600;
        push_expect(1'b1, "R2 second loss");
        sec_en = 1'b0;
        #2000;
        push_expect(1'b1, "R7 both stopped on backup");
        sec_en = 1'b1;
        #1000;
        push_expect(1'b1, "R7 backup back, main still absent");
        pri_en = 1'b1;
        #2500;
        push_expect(1'b0, "R4 second revert");

        pri_en = 1'b0;
        sec_en = 1'b0;
        #2000;
        push_expect(1'b0, "R7 both stopped on main");
        pri_en = 1'b1;
        sec_en = 1'b1;
        #1000;
        push_expect(1'b0, "R3 both restarted");

        repeat (4) @(negedge clk_mon);
        finish_run();
    end
endmodule